// File: doc/BRIEF.md
# Page-Buffered Self-Timed Write Controller

This block sits behind the command front end of a serial memory. It takes the byte address that the front end captured for a write command and the data bytes that follow it. The bytes are gathered in a page buffer whose size is a power of two, 64 bytes by default. When the host deselects the device on a clean byte boundary after at least one full data byte, the controller commits the gathered page to its byte array. The commit runs as one internal program cycle whose length is a parameter counted in clock cycles, standing in for the physical program time.

The write address splits in two. The high bits pick the page and stay fixed for the whole sequence. The low bits pick the slot in the page and advance by one per byte, wrapping back to slot zero of the same page. Only slots that received a byte change their array location. During the program cycle the controller shows busy and ignores every new open, byte and deselect event. When the cycle ends it sends a one-cycle pulse that tells the status logic to clear its write-enable latch. Whether a write is allowed at all is decided outside and arrives as a single permit input.

The array depth is set by `ARRAY_AW`. At full size this is 14 bits, which gives 16K bytes. The default is 11 bits, so that elaboration stays small. A read port gives direct access to the array contents.

Top module: `pgw_ctrl`

## Requirements
- R1: After reset every array byte reads FFh, and `busy` and `wel_clr` are 0.
- R2: The k-th data byte (k = 0, 1, ...) of a sequence opened at address A is stored at array address {A[ARRAY_AW-1:6], (A[5:0] + k) mod 64}. Address bits 15 down to ARRAY_AW are ignored.
- R3: When more than 64 bytes are loaded, loading wraps inside the same page, and a later byte replaces an earlier byte at the same slot.
- R4: A program cycle starts only on a `desel` pulse during loading after at least one complete byte, with `desel_aligned` = 1 and `wr_permit` = 1. In every other case the loaded data is discarded, `busy` stays 0 and the array is unchanged.
- R5: `busy` goes to 1 in the cycle after the accepted `desel` and stays 1 for exactly PROG_CYCLES cycles.
- R6: While `busy` is 1, `wr_open`, `byte_vld` and `desel` have no effect. No other page changes, and no second program cycle follows.
- R7: `wel_clr` is a single-cycle pulse, given in the first cycle after the end of each program cycle, and is 0 at all other times.
- R8: Slots of the page that received no byte in the sequence keep their previous array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_open | input | 1 | Pulse: a write sequence starts at `start_addr` |
| start_addr | input | 16 | Byte address captured by the front end |
| byte_vld | input | 1 | Pulse: one complete data byte on `byte_data` |
| byte_data | input | 8 | Data byte |
| desel | input | 1 | Pulse: chip select went inactive |
| desel_aligned | input | 1 | Deselect fell on a byte boundary (qualifies `desel`) |
| wr_permit | input | 1 | Protection policy allows this write (qualifies `desel`) |
| rd_addr | input | 16 | Array read address (high bits ignored) |
| busy | output | 1 | Internal program cycle in progress |
| wel_clr | output | 1 | One-cycle pulse: clear the write-enable latch |
| rd_data | output | 8 | Array byte at `rd_addr`, combinational |

## Verification
Inputs are driven on the falling edge, so the rising edge that follows samples them. An accepted deselect therefore shows `busy` high at the very next falling edge. The bench samples `busy` on PROG_CYCLES successive falling edges and expects all of them high. At the next falling edge it expects `busy` low with `wel_clr` high, and one edge later `wel_clr` low. A rejected deselect is watched for several edges, and neither output may rise. Array contents are read through the combinational read port only after the busy window has closed, one address per cycle, and compared with a page model that the bench builds from the wrap and merge rules.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    localparam int PGW_DATA_W    = 8;
    localparam int PGW_PAGE_AW   = 6;
    localparam int PGW_ADDR_IN_W = 16;

    typedef enum logic [1:0] {
        PGW_IDLE = 2'd0,
        PGW_LOAD = 2'd1,
        PGW_PROG = 2'd2
    } pgw_state_e;

    // One page-buffer slot: a loaded flag plus the byte it holds.
    typedef struct packed {
        logic                  vld;
        logic [PGW_DATA_W-1:0] data;
    } pgw_slot_t;

    // Array write request produced while committing a page.
    typedef struct packed {
        logic                  en;
        logic [PGW_DATA_W-1:0] data;
    } pgw_commit_t;

    function automatic int pgw_elapsed_w(input int cycles);
        return (cycles > 1) ? $clog2(cycles) : 1;
    endfunction

endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf
    import pgw_pkg::*;
#(
    parameter int PAGE_AW = PGW_PAGE_AW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic [PAGE_AW-1:0]    wr_off,
    input  logic [PGW_DATA_W-1:0] wr_data,
    input  logic [PAGE_AW-1:0]    rd_off,
    output pgw_slot_t             rd_slot
);

    localparam int SLOTS = 1 << PAGE_AW;

    pgw_slot_t [SLOTS-1:0] slot_vec;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            pgw_slot_t s_q;
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    s_q <= '0;
                end else if (wr_en && (wr_off == PAGE_AW'(g))) begin
                    s_q.vld  <= 1'b1;
                    s_q.data <= wr_data;
                end
            end
            assign slot_vec[g] = s_q;
        end
    endgenerate

    assign rd_slot = slot_vec[rd_off];

    // A written slot reads back as loaded with the new byte.
    AST_SLOT_LOADED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> (slot_vec[$past(wr_off)].vld &&
                             slot_vec[$past(wr_off)].data == $past(wr_data))); // R3

endmodule

// File: rtl/pgw_prog_timer.sv
module pgw_prog_timer
    import pgw_pkg::*;
#(
    parameter int PROG_CYCLES = 100,
    parameter int EL_W        = pgw_elapsed_w(PROG_CYCLES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic            busy,
    output logic            done,
    output logic [EL_W-1:0] elapsed
);

    localparam logic [EL_W-1:0] LAST = EL_W'(PROG_CYCLES - 1);

    logic            busy_q;
    logic            done_q;
    logic [EL_W-1:0] el_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            el_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    el_q   <= '0;
                end
            end else if (el_q == LAST) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                el_q <= el_q + 1'b1;
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign elapsed = el_q;

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy_q && el_q != LAST) |=> busy_q); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R7

endmodule

// File: rtl/pgw_array.sv
module pgw_array
    import pgw_pkg::*;
#(
    parameter int ARRAY_AW = 11
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ARRAY_AW-1:0]   waddr,
    input  logic [PGW_DATA_W-1:0] wdata,
    input  logic [ARRAY_AW-1:0]   raddr,
    output logic [PGW_DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ARRAY_AW;

    logic [PGW_DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
    import pgw_pkg::*;
#(
    parameter int ARRAY_AW    = 11,
    parameter int PAGE_AW     = PGW_PAGE_AW,
    parameter int PROG_CYCLES = 100
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_open,
    input  logic [PGW_ADDR_IN_W-1:0] start_addr,
    input  logic                     byte_vld,
    input  logic [PGW_DATA_W-1:0]    byte_data,
    input  logic                     desel,
    input  logic                     desel_aligned,
    input  logic                     wr_permit,
    input  logic [PGW_ADDR_IN_W-1:0] rd_addr,
    output logic                     busy,
    output logic                     wel_clr,
    output logic [PGW_DATA_W-1:0]    rd_data
);

    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int PAGE_NUM_W = ARRAY_AW - PAGE_AW;
    localparam int EL_W       = pgw_elapsed_w(PROG_CYCLES);
    localparam logic [EL_W:0] COMMIT_END = (EL_W + 1)'(PAGE_BYTES);

    generate
        if (PROG_CYCLES < PAGE_BYTES) begin : g_bad_prog
            $error("PROG_CYCLES must cover one cycle per page slot");
        end
    endgenerate

    pgw_state_e              state_q;
    logic [PAGE_NUM_W-1:0]   page_q;
    logic [PAGE_AW-1:0]      off_q;
    logic                    loaded_q;

    logic                    buf_clr;
    logic                    buf_wr;
    logic                    start_ok;
    logic                    tmr_busy;
    logic                    tmr_done;
    logic [EL_W-1:0]         tmr_el;
    pgw_slot_t               commit_slot;
    pgw_commit_t             commit;
    logic [ARRAY_AW-1:0]     commit_addr;
    logic                    unused_hi;

    assign unused_hi = ^{start_addr[PGW_ADDR_IN_W-1:ARRAY_AW], rd_addr[PGW_ADDR_IN_W-1:ARRAY_AW]};

    // Input qualification: nothing from the front end is taken while programming.
    assign buf_clr  = wr_open && (state_q != PGW_PROG);
    assign buf_wr   = (state_q == PGW_LOAD) && byte_vld && !wr_open && !desel;
    assign start_ok = (state_q == PGW_LOAD) && !wr_open && desel &&
                      loaded_q && desel_aligned && wr_permit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PGW_IDLE;
            page_q   <= '0;
            off_q    <= '0;
            loaded_q <= 1'b0;
        end else begin
            unique case (state_q)
                PGW_IDLE, PGW_LOAD: begin
                    if (wr_open) begin
                        state_q  <= PGW_LOAD;
                        page_q   <= start_addr[ARRAY_AW-1:PAGE_AW];
                        off_q    <= start_addr[PAGE_AW-1:0];
                        loaded_q <= 1'b0;
                    end else if (state_q == PGW_LOAD) begin
                        if (desel) begin
                            state_q <= start_ok ? PGW_PROG : PGW_IDLE;
                        end else if (byte_vld) begin
                            off_q    <= off_q + 1'b1;
                            loaded_q <= 1'b1;
                        end
                    end
                end
                PGW_PROG: begin
                    if (tmr_done) begin
                        state_q <= PGW_IDLE;
                    end
                end
                default: state_q <= PGW_IDLE;
            endcase
        end
    end

    pgw_page_buf #(
        .PAGE_AW (PAGE_AW)
    ) u_buf (
        .clk     (clk),
        .rst     (rst),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_off  (off_q),
        .wr_data (byte_data),
        .rd_off  (tmr_el[PAGE_AW-1:0]),
        .rd_slot (commit_slot)
    );

    pgw_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .EL_W        (EL_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (start_ok),
        .busy    (tmr_busy),
        .done    (tmr_done),
        .elapsed (tmr_el)
    );

    // Commit walks the page one slot per cycle in the opening part of the busy window.
    always_comb begin
        commit.en   = tmr_busy && ({1'b0, tmr_el} < COMMIT_END) && commit_slot.vld;
        commit.data = commit_slot.data;
        commit_addr = {page_q, tmr_el[PAGE_AW-1:0]};
    end

    pgw_array #(
        .ARRAY_AW (ARRAY_AW)
    ) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (commit.en),
        .waddr (commit_addr),
        .wdata (commit.data),
        .raddr (rd_addr[ARRAY_AW-1:0]),
        .rdata (rd_data)
    );

    assign busy    = tmr_busy;
    assign wel_clr = tmr_done;

    AST_START_ON_DESEL: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(desel && desel_aligned && wr_permit && loaded_q)); // R4

    AST_OFF_STEP: assert property (@(posedge clk) disable iff (rst)
        buf_wr |=> (off_q == $past(off_q) + 1'b1)); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(page_q) && $stable(off_q))); // R6

    AST_PROG_STATE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (state_q == PGW_PROG)); // R6

    AST_CLR_ON_FINISH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> wel_clr); // R7

    AST_CLR_ONLY_AFTER: assert property (@(posedge clk) disable iff (rst)
        wel_clr |-> ($past(busy) && !busy)); // R7

endmodule

// File: tb/tb_pgw_ctrl.sv
module tb_pgw_ctrl;

    localparam int AW    = 11;
    localparam int PROG  = 100;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_open = 1'b0;
    logic [15:0] start_addr = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        desel = 1'b0;
    logic        desel_aligned = 1'b0;
    logic        wr_permit = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        busy;
    logic        wel_clr;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] mdl [DEPTH];
    logic [7:0] pay [200];

    always #5 clk = ~clk;

    pgw_ctrl #(
        .ARRAY_AW    (AW),
        .PAGE_AW     (6),
        .PROG_CYCLES (PROG)
    ) dut (
        .clk           (clk),
        .rst           (rst),
        .wr_open       (wr_open),
        .start_addr    (start_addr),
        .byte_vld      (byte_vld),
        .byte_data     (byte_data),
        .desel         (desel),
        .desel_aligned (desel_aligned),
        .wr_permit     (wr_permit),
        .rd_addr       (rd_addr),
        .busy          (busy),
        .wel_clr       (wel_clr),
        .rd_data       (rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int mdl_index(input logic [15:0] a, input int k);
        logic [5:0] off;
        off = 6'(int'(a[5:0]) + k);
        return int'({a[AW-1:6], off});
    endfunction

    // All tasks start and end at a falling edge.
    task automatic open_seq(input logic [15:0] a);
        wr_open = 1'b1; start_addr = a;
        @(negedge clk);
        wr_open = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        byte_vld = 1'b1; byte_data = d;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic deselect(input bit al, input bit pm);
        desel = 1'b1; desel_aligned = al; wr_permit = pm;
        @(negedge clk);
        desel = 1'b0;
    endtask

    task automatic watch_prog(input bit expect_go, input bit inject, input string req);
        if (expect_go) begin
            int hi = 0;
            bit early_clr = 1'b0;
            for (int i = 0; i < PROG; i++) begin
                if (busy) hi++;
                if (wel_clr) early_clr = 1'b1;
                if (inject) begin
                    if (i == 10) begin wr_open = 1'b1; start_addr = 16'h0000; end
                    if (i == 11) begin wr_open = 1'b0; byte_vld = 1'b1; byte_data = 8'h5A; end
                    if (i == 12) begin byte_vld = 1'b0; desel = 1'b1; desel_aligned = 1'b1; wr_permit = 1'b1; end
                    if (i == 13) desel = 1'b0;
                end
                @(negedge clk);
            end
            chk(hi == PROG, "R5", "busy cycles", hi, PROG);
            chk(!early_clr, "R7", "wel_clr inside window", int'(early_clr), 0);
            chk(!busy && wel_clr, "R7", "busy/wel_clr at end", int'({busy, wel_clr}), 1);
            @(negedge clk);
            chk(!wel_clr, "R7", "wel_clr width", int'(wel_clr), 0);
        end else begin
            int seen = 0;
            for (int i = 0; i < 4; i++) begin
                if (busy || wel_clr) seen++;
                @(negedge clk);
            end
            chk(seen == 0, req, "no program cycle", seen, 0);
        end
    endtask

    task automatic check_page(input logic [15:0] a, input string req);
        int bad = 0;
        int bad_act = 0;
        int bad_exp = 0;
        for (int o = 0; o < 64; o++) begin
            rd_addr = {a[15:6], 6'(o)};
            #1;
            if (rd_data !== mdl[mdl_index({a[15:6], 6'd0}, o)]) begin
                if (bad == 0) begin
                    bad_act = int'(rd_data);
                    bad_exp = int'(mdl[mdl_index({a[15:6], 6'd0}, o)]);
                end
                bad++;
            end
            @(negedge clk);
        end
        chk(bad == 0, req, "page contents", bad_act, bad_exp);
    endtask

    task automatic run_write(input logic [15:0] a, input int n, input bit al,
                             input bit pm, input bit inject, input string req);
        bit go;
        open_seq(a);
        for (int k = 0; k < n; k++) send_byte(pay[k]);
        deselect(al, pm);
        go = (n > 0) && al && pm;
        if (go) begin
            for (int k = 0; k < n; k++) mdl[mdl_index(a, k)] = pay[k];
        end
        watch_prog(go, inject, req);
        check_page(a, req);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        for (int i = 0; i < DEPTH; i++) mdl[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state and erased array
        chk(!busy && !wel_clr, "R1", "outputs after reset", int'({busy, wel_clr}), 0);
        begin
            int bad = 0;
            for (int i = 0; i < DEPTH; i++) begin
                rd_addr = 16'(i);
                #1;
                if (rd_data !== 8'hFF) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R1", "non-erased bytes", bad, 0);
        end

        // R2: plain placement, upper address bits ignored
        for (int k = 0; k < 5; k++) pay[k] = 8'(8'h10 + k);
        run_write(16'hF905, 5, 1'b1, 1'b1, 1'b0, "R2");
        check_page(16'h0105, "R2");

        // R3: wrap within page with overwrite
        for (int k = 0; k < 70; k++) pay[k] = 8'(k * 3 + 1);
        run_write(16'h0210, 70, 1'b1, 1'b1, 1'b0, "R3");

        // R8: a short write leaves the rest of an earlier page intact
        pay[0] = 8'hA1; pay[1] = 8'hA2;
        run_write(16'h0107, 2, 1'b1, 1'b1, 1'b0, "R8");

        // R4: rejected deselects
        run_write(16'h0300, 0, 1'b1, 1'b1, 1'b0, "R4");
        for (int k = 0; k < 3; k++) pay[k] = 8'h77;
        run_write(16'h0300, 3, 1'b0, 1'b1, 1'b0, "R4");
        run_write(16'h0300, 3, 1'b1, 1'b0, 1'b0, "R4");

        // R6: stimulus during the busy window is ignored
        for (int k = 0; k < 4; k++) pay[k] = 8'(8'hC0 + k);
        run_write(16'h0440, 4, 1'b1, 1'b1, 1'b1, "R6");
        begin
            int seen = 0;
            for (int i = 0; i < 5; i++) begin
                if (busy || wel_clr) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R6", "second program after window", seen, 0);
        end
        check_page(16'h0000, "R6");

        // Random sequences
        for (int it = 0; it < 16; it++) begin
            logic [15:0] a;
            int n;
            bit al;
            bit pm;
            a  = 16'($urandom);
            n  = ($urandom % 8 == 0) ? 0 : int'($urandom % 130) + 1;
            al = ($urandom % 5) != 0;
            pm = ($urandom % 5) != 0;
            for (int k = 0; k < n; k++) pay[k] = 8'($urandom);
            run_write(a, n, al, pm, 1'b0, "R2");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule